// File: doc/BRIEF.md
# Multi-Digit Decimal Adder-Subtractor

This block adds or subtracts two unsigned decimal numbers held as packed 8421 BCD, one nibble per digit, with the least significant digit in bits 3:0. The number of digits is a parameter. The block is purely combinational: the result and the final decimal carry follow the operands and the mode bit with no clock.

Each digit is formed by a binary add of the two operand digits and the incoming carry. When that binary sum is above nine, six is added to it and a decimal carry goes to the next higher digit. The carries ripple from the lowest digit to the highest. When subtraction is selected, every subtrahend digit is swapped for its nines complement and the lowest digit receives a carry of one. The result is then the difference in tens-complement form, and the final carry shows whether the difference is non-negative. Operands must hold legal digits (0 to 9). The block neither checks illegal codes nor converts a negative result to sign and magnitude.

Top module: `bcd_addsub`

## Requirements
- R1: With `subMode` = 0 and legal operands, `{carryOut, result}` equals the decimal sum opA + opB. `carryOut` carries weight 10^DIGITS, and each result nibble holds one decimal digit in 8421 code.
- R2: For legal operands in either mode, every 4-bit digit of `result` is in the range 0000 to 1001.
- R3: A digit whose binary sum of operand digits and incoming carry is 9 or less appears in `result` unchanged and passes no carry upward. For example, 1234 + 4321 gives 5555 with `carryOut` = 0, and adding zero returns the other operand.
- R4: A digit whose binary sum is 10 to 19 is corrected by adding six and passes a carry of one to the next digit. For example, 0009 + 0009 gives 0018, and 0005 + 0005 gives 0010.
- R5: Decimal carries ripple from the least significant digit upward through any run of nines. For example, 0999 + 0001 gives 1000, and 9999 + 0001 gives 0000 with `carryOut` = 1.
- R6: With `subMode` = 1, `result` equals (opA − opB) mod 10^DIGITS, and `carryOut` is 1 exactly when opA ≥ opB.
- R7: Subtracting equal operands yields zero with `carryOut` = 1. Subtracting zero returns opA with `carryOut` = 1.
- R8: The largest sum, all nines plus all nines, yields all nines except a least significant digit of 8, with `carryOut` = 1. For example, 9999 + 9999 gives 9998 with carry 1.
- R9: A negative difference appears as the tens complement with `carryOut` = 0. For example, 0000 − 0001 gives 9999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4*DIGITS | First operand (augend or minuend), packed BCD, lowest digit in bits 3:0 |
| opB | input | 4*DIGITS | Second operand (addend or subtrahend), packed BCD |
| subMode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 4*DIGITS | Packed BCD sum or tens-complement difference |
| carryOut | output | 1 | Decimal carry out of the highest digit; in subtract mode, 1 means the result is non-negative |

## Verification
Directed vectors cover each side of the correction threshold. Digit sums of 9 or less separate the pass-through path from the corrected path, and sums of exactly 10 and of 18 with a carry in check the add-six correction at both ends of its range. Runs of nines with a carry injected at the bottom show whether the carry reaches the top digit. Subtractions with equal operands, a zero subtrahend and a larger subtrahend tell a correct complement and carry seed apart from an off-by-one or a missing seed. Random legal operands in both modes are then compared against an integer decimal model.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  typedef logic [3:0] bcdDigit_t;

  // Strobes handed from the mode control to the digit datapath
  typedef struct packed {
    logic complementSub;  // replace each subtrahend digit by 9 - digit
    logic carrySeed;      // carry injected into the lowest digit
  } modeStrobes_t;

  localparam bcdDigit_t DIGIT_NINE = 4'd9;
  localparam bcdDigit_t DIGIT_SIX  = 4'd6;

endpackage

// File: rtl/bcd_mode_ctrl.sv
module bcd_mode_ctrl
  import bcd_addsub_pkg::*;
(
  input  logic         subMode,
  output modeStrobes_t strobes
);

  // Subtraction = add nines complement plus one at the bottom digit
  always_comb begin
    strobes.complementSub = subMode;
    strobes.carrySeed     = subMode;
  end

endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_addsub_pkg::*;
(
  input  bcdDigit_t augend,
  input  bcdDigit_t addend,
  input  logic      complementAddend,
  input  logic      carryIn,
  output bcdDigit_t digitSum,
  output logic      decimalCarry
);

  bcdDigit_t  effAddend;
  logic [4:0] rawSum;
  logic       needFix;
  bcdDigit_t  fixValue;

  // Optional nines complement of the second operand digit
  assign effAddend = complementAddend ? (DIGIT_NINE - addend) : addend;

  // First binary adder: operand digits plus incoming carry
  assign rawSum = {1'b0, augend} + {1'b0, effAddend} + {4'b0000, carryIn};

  // Sum above nine: binary carry, or 1010..1111 in the low nibble
  assign needFix = rawSum[4] | (rawSum[3] & rawSum[2]) | (rawSum[3] & rawSum[1]);

  // Second binary adder: add six or zero, drop the carry out
  assign fixValue     = needFix ? DIGIT_SIX : 4'd0;
  assign digitSum     = rawSum[3:0] + fixValue;
  assign decimalCarry = needFix;

endmodule

// File: rtl/bcd_chain_datapath.sv
module bcd_chain_datapath
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  modeStrobes_t        strobes,
  output logic [4*DIGITS-1:0] result,
  output logic                carryOut
);

  logic [DIGITS:0] carryChain;

  assign carryChain[0] = strobes.carrySeed;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_stage u_stage (
      .augend          (opA[4*d +: 4]),
      .addend          (opB[4*d +: 4]),
      .complementAddend(strobes.complementSub),
      .carryIn         (carryChain[d]),
      .digitSum        (result[4*d +: 4]),
      .decimalCarry    (carryChain[d+1])
    );
  end

  assign carryOut = carryChain[DIGITS];

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  logic                subMode,
  output logic [4*DIGITS-1:0] result,
  output logic                carryOut
);

  modeStrobes_t strobes;

  bcd_mode_ctrl u_ctrl (
    .subMode(subMode),
    .strobes(strobes)
  );

  bcd_chain_datapath #(.DIGITS(DIGITS)) u_path (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut)
  );

endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int DIGITS = 4
) (
  input logic [4*DIGITS-1:0] opA,
  input logic [4*DIGITS-1:0] opB,
  input logic                subMode,
  input logic [4*DIGITS-1:0] result,
  input logic                carryOut
);

  function automatic logic allLegal(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  logic inLegal;
  assign inLegal = allLegal(opA) && allLegal(opB);

  always_comb begin
    // R2: legal operands give legal result digits
    a_r2_digits_legal: assert (!inLegal || allLegal(result))
      else $error("result holds an illegal digit");
    // R3: adding zero passes the other operand through with no carry
    a_r3_add_zero: assert (!(inLegal && !subMode && opA == '0) ||
                           (result == opB && !carryOut))
      else $error("zero plus B differs from B");
    // R7: equal operands subtract to zero with carry set
    a_r7_sub_equal: assert (!(inLegal && subMode && opA == opB) ||
                            (result == '0 && carryOut))
      else $error("A minus A is not zero");
    // R7: subtracting zero returns A with carry set
    a_r7_sub_zero: assert (!(inLegal && subMode && opB == '0) ||
                           (result == opA && carryOut))
      else $error("A minus zero differs from A");
  end

endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .subMode (subMode),
  .result  (result),
  .carryOut(carryOut)
);

// File: tb/tb_bcd_addsub.sv
module tb_bcd_addsub;

  localparam int DIGITS = 4;
  localparam int W      = 4 * DIGITS;
  localparam int MODV   = 10000;   // 10^DIGITS

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         subMode = 1'b0;
  logic [W-1:0] result;
  logic         carryOut;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;

  always #2 clk = ~clk;  // 250 MHz

  bcd_addsub #(.DIGITS(DIGITS)) dut (
    .opA(opA), .opB(opB), .subMode(subMode),
    .result(result), .carryOut(carryOut)
  );

  function automatic int toInt(input logic [W-1:0] v);
    int n;
    n = 0;
    for (int i = DIGITS - 1; i >= 0; i--) n = n * 10 + int'(v[4*i +: 4]);
    return n;
  endfunction

  function automatic logic [W-1:0] toBcd(input int n);
    logic [W-1:0] v;
    int m;
    m = n;
    v = '0;
    for (int i = 0; i < DIGITS; i++) begin
      v[4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return v;
  endfunction

  // Behavioural decimal reference, one vector per clock
  task automatic runVec(input int a, input int b, input logic sub, input string tag);
    int expInt;
    logic expC;
    logic [W-1:0] expR;
    @(negedge clk);
    opA = toBcd(a);
    opB = toBcd(b);
    subMode = sub;
    if (sub) begin
      expInt = a - b + MODV;
      expC   = (a >= b);
    end else begin
      expInt = a + b;
      expC   = (expInt >= MODV);
    end
    expR = toBcd(expInt % MODV);
    @(posedge clk);
    #1;
    compared++;
    if (result !== expR || carryOut !== expC) begin
      mismatched++;
      $display("FAIL %s: %0d %s %0d -> got %h c%b, expected %h c%b",
               tag, a, sub ? "-" : "+", b, result, carryOut, expR, expC);
    end
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    mismatched++;
    compared++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;
    runVec(0, 0, 1'b0, "reset R1");
    runVec(1234, 4321, 1'b0, "R3 no correction");
    runVec(0, 8765, 1'b0, "R3 zero augend");
    runVec(9, 9, 1'b0, "R4 nine plus nine");
    runVec(5, 5, 1'b0, "R4 exactly ten");
    runVec(4, 5, 1'b0, "R4 exactly nine");
    runVec(999, 1, 1'b0, "R5 ripple");
    runVec(9999, 1, 1'b0, "R5 ripple to carry out");
    runVec(9999, 9999, 1'b0, "R8 maximum");
    runVec(5678, 4567, 1'b0, "R1 mixed");
    runVec(8000, 1234, 1'b1, "R6 positive difference");
    runVec(4321, 4321, 1'b1, "R7 equal");
    runVec(6543, 0, 1'b1, "R7 minus zero");
    runVec(0, 1, 1'b1, "R9 zero minus one");
    runVec(1234, 5678, 1'b1, "R9 negative");
    runVec(1000, 1, 1'b1, "R6 borrow ripple");
    for (int i = 0; i < 400; i++) begin
      runVec($urandom_range(MODV - 1), $urandom_range(MODV - 1), 1'b0, "R1 R2 random add");
      runVec($urandom_range(MODV - 1), $urandom_range(MODV - 1), 1'b1, "R6 R2 random sub");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule